// File: doc/BRIEF.md
# Split Modulo-Six Up/Down Counter

This block counts 0 through 5 and wraps in both directions, but it is not one six-state machine. It is two small four-state machines that pass control back and forth. The low machine owns counts 0, 1 and 2 and has a parked state of its own. The high machine owns counts 3, 4 and 5 and also has a parked state. Each machine watches the other's state. It leaves its parked state only when the other machine is about to step across the boundary toward it.

At any moment exactly one machine is live. The count output is decoded from the live machine. Two single-bit outputs show which half holds control, so the handoff can be seen at the pins. Use the block wherever a small wrapping position counter is needed and short next-state logic per machine is worth one extra flip-flop.

Top module: `updown6_split`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `count` is 0, `lo_live` is 1 and `hi_live` is 0.
- R2: On a clock edge where `up`=1 and `dn`=0, `count` advances by one, and 5 wraps to 0.
- R3: On a clock edge where `dn`=1 and `up`=0, `count` drops by one, and 0 wraps to 5.
- R4: On a clock edge where `up` and `dn` are equal (both 0 or both 1), `count`, `lo_live` and `hi_live` keep their values.
- R5: Exactly one of `lo_live` and `hi_live` is 1 in every cycle.
- R6: `hi_live` is 1 exactly when `count` is 3, 4 or 5, and `lo_live` is 1 exactly when `count` is 0, 1 or 2.
- R7: An up step from 2, or a down step from 0, parks the low machine and starts the high machine in the same edge. The results are `count`=3 and `count`=5, with `hi_live`=1.
- R8: An up step from 5, or a down step from 3, parks the high machine and restarts the low machine in the same edge. The results are `count`=0 and `count`=2, with `lo_live`=1.
- R9: A run of consecutive up steps gives the same count sequence as a single modulo-6 counter, 0,1,2,3,4,5,0,...

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up | input | 1 | Step toward higher counts |
| dn | input | 1 | Step toward lower counts |
| count | output | 3 | Current count, 0..5 |
| lo_live | output | 1 | Low machine (counts 0..2) holds control |
| hi_live | output | 1 | High machine (counts 3..5) holds control |

## Verification
At a boundary crossing, one machine parks itself and the other wakes up from its park state on the same clock edge. Both decisions depend on the same input and on each other's state. The bench creates every crossing: up from 2, down from 0, up from 5 and down from 3. At each one it compares the count and both live flags with a single-counter reference computed in the bench, so a one-cycle gap (no machine live) or overlap (both live) shows up. It also holds with both strobes high right at a boundary. This confirms that neither machine starts a handoff on its own.

// File: rtl/updown6_split.sv
module updown6_split (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up,
  input  logic       dn,
  output logic [2:0] count,
  output logic       lo_live,
  output logic       hi_live
);
  // low machine: 0,1,2 are counts 0..2, 3 is parked
  // high machine: 0,1,2 are counts 3..5, 3 is parked
  localparam logic [1:0] P0 = 2'd0, P1 = 2'd1, P2 = 2'd2, PARK = 2'd3;

  logic [1:0] lo_q, lo_d, hi_q, hi_d;
  logic inc, dec;

  assign inc = up & ~dn;
  assign dec = dn & ~up;

  always_comb begin
    lo_d = lo_q;
    unique case (lo_q)
      P0:   if (inc) lo_d = P1; else if (dec) lo_d = PARK;
      P1:   if (inc) lo_d = P2; else if (dec) lo_d = P0;
      P2:   if (inc) lo_d = PARK; else if (dec) lo_d = P1;
      PARK: if (inc && hi_q == P2) lo_d = P0;
            else if (dec && hi_q == P0) lo_d = P2;
    endcase
  end

  always_comb begin
    hi_d = hi_q;
    unique case (hi_q)
      P0:   if (inc) hi_d = P1; else if (dec) hi_d = PARK;
      P1:   if (inc) hi_d = P2; else if (dec) hi_d = P0;
      P2:   if (inc) hi_d = PARK; else if (dec) hi_d = P1;
      PARK: if (inc && lo_q == P2) hi_d = P0;
            else if (dec && lo_q == P0) hi_d = P2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= P0;
      hi_q <= PARK;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_live = (lo_q != PARK);
  assign hi_live = (hi_q != PARK);
  assign count   = lo_live ? {1'b0, lo_q} : 3'd3 + {1'b0, hi_q};
endmodule

// File: rtl/updown6_split_chk.sv
module updown6_split_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       up,
  input logic       dn,
  input logic [2:0] count,
  input logic       lo_live,
  input logic       hi_live
);
  p_one_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_live ^ hi_live);

  p_half_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_live == (count >= 3'd3));

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn) |=> count == (($past(count) == 3'd5) ? 3'd0 : $past(count) + 3'd1));

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !up) |=> count == (($past(count) == 3'd0) ? 3'd5 : $past(count) - 3'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up == dn) |=> ($stable(count) && $stable(hi_live)));

  p_to_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((up && !dn && count == 3'd2) || (dn && !up && count == 3'd0)) |=> hi_live);

  p_to_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((up && !dn && count == 3'd5) || (dn && !up && count == 3'd3)) |=> lo_live);
endmodule

bind updown6_split updown6_split_chk chk (
  .clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
  .count(count), .lo_live(lo_live), .hi_live(hi_live)
);

// File: tb/updown6_split_test.sv
module updown6_split_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0;
  logic dn = 1'b0;
  logic [2:0] count;
  logic lo_live, hi_live;
  int errors = 0;
  int checks = 0;
  int ref_cnt = 0;

  always #10 clk = ~clk;

  updown6_split uut (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
    .count(count), .lo_live(lo_live), .hi_live(hi_live)
  );

  // {up, dn, expected count after the edge}
  localparam logic [4:0] VEC [24] = '{
    {2'b10, 3'd1}, {2'b10, 3'd2}, {2'b10, 3'd3}, {2'b10, 3'd4},
    {2'b10, 3'd5}, {2'b10, 3'd0}, {2'b01, 3'd5}, {2'b01, 3'd4},
    {2'b01, 3'd3}, {2'b01, 3'd2}, {2'b00, 3'd2}, {2'b11, 3'd2},
    {2'b01, 3'd1}, {2'b01, 3'd0}, {2'b10, 3'd1}, {2'b01, 3'd0},
    {2'b01, 3'd5}, {2'b10, 3'd0}, {2'b10, 3'd1}, {2'b10, 3'd2},
    {2'b01, 3'd1}, {2'b10, 3'd2}, {2'b10, 3'd3}, {2'b01, 3'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " count"}, count, ref_cnt);
    check({req, "/R6 hi_live"}, hi_live, ref_cnt >= 3);
    check({req, "/R5 one live"}, lo_live ^ hi_live, 1);
  endtask

  // inputs change at negedge; the result is sampled one negedge later
  task automatic step(input logic u, input logic d);
    up = u; dn = d;
    if (u && !d) ref_cnt = (ref_cnt + 1) % 6;
    else if (d && !u) ref_cnt = (ref_cnt + 5) % 6;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 count in reset", count, 0);
    check("R1 lo_live in reset", lo_live, 1);
    check("R1 hi_live in reset", hi_live, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", count, 0);

    for (int i = 0; i < 24; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check($sformatf("R2/R3/R4 vec %0d table", i), count, VEC[i][2:0]);
      check_state($sformatf("R7/R8 vec %0d", i));
    end

    // R8: up from 5 hands back to low machine
    while (ref_cnt != 5) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R8 up 5->0 lo_live", lo_live, 1);
    check_state("R8 up wrap");
    // R4: both strobes at a boundary do not start a handoff
    while (ref_cnt != 2) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R4 both at 2 lo_live", lo_live, 1);
    check_state("R4 both at 2");
    step(1'b0, 1'b0);
    check_state("R4 idle at 2");

    // R9: long up run against reference
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0);
      check_state($sformatf("R9 run %0d", i));
    end
    // R7: down from 0
    while (ref_cnt != 0) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R7 down 0->5 hi_live", hi_live, 1);
    check_state("R7 down wrap");

    // R1: reset mid-run from the high half
    rst_n = 1'b0; up = 1'b1; dn = 1'b0;
    @(negedge clk);
    check("R1 mid reset count", count, 0);
    check("R1 mid reset hi_live", hi_live, 0);
    up = 1'b0;
    rst_n = 1'b1; ref_cnt = 0;
    @(negedge clk);
    check_state("R1 after mid reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule